// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is a byte-wide first-in first-out buffer for instruction bytes. It sits between the fetch engine of a bus interface and an execution unit. The fetch side reads code memory one address after another through a request/acknowledge port. It forms each 20-bit address from a 16-bit segment value and a 16-bit offset, and it appends the returned bytes to the queue. The execute side takes bytes one at a time whenever the queue shows a valid byte. Both sides work in the same cycle.

Two parameters set the queue depth and the bus width in bytes. The wide setting (16-bit bus, 6 bytes deep) fetches a word at a time and starts a fetch only when at least two byte slots are free. The narrow setting (8-bit bus, 4 bytes deep) fetches one byte at a time and starts a fetch as soon as one slot is free.

A control transfer pulses `flush` with a new segment and offset. This empties the queue in one cycle and moves fetching to the new location. Data still returning for a request made before the flush is thrown away.

Top module: `prefetch_queue`

## Requirements
- R1: Bytes leave the queue on `exe_byte` in exactly the order of their code addresses. The byte at the lower address of a fetched word (carried on `mem_rdata[7:0]`) comes before the one at the higher address (carried on `mem_rdata[15:8]`).
- R2: The queue never holds more than DEPTH bytes. With no pops, fetching stops once the queue is full. Six bytes (three word fetches) fill the queue when it starts at an even offset.
- R3: With a two-byte bus, a new request rises only when at least two slots are free. A queue holding five bytes issues no request.
- R4: With a one-byte bus, a new request rises when one slot is free. A single pop from a full queue is followed by a request.
- R5: A pop and an appended fetch in the same cycle both take effect, and no byte is lost or duplicated.
- R6: `mem_addr` equals the segment shifted left by 4 bits plus the offset, truncated to 20 bits.
- R7: After a `flush` edge, `exe_valid` is low. The next request targets the new segment and offset.
- R8: A request outstanding at a flush stays on the port until it is acknowledged. Its data is discarded and does not enter the queue.
- R9: On the two-byte bus, a fetch from an odd address appends only `mem_rdata[15:8]`. The following fetch uses the next, even, address.
- R10: A pop while `exe_valid` is low is ignored. It does not consume a later byte.
- R11: The offset wraps from FFFFh to 0000h within the same segment.
- R12: While `mem_req` is high and not acknowledged, `mem_req` and `mem_addr` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Control transfer: empty the queue and load a new fetch location |
| flush_seg | input | 16 | New segment value, taken on flush |
| flush_off | input | 16 | New offset value, taken on flush |
| mem_req | output | 1 | Code read request, held until acknowledged |
| mem_addr | output | 20 | Physical address of the read |
| mem_ack | input | 1 | One-cycle acknowledge carrying read data |
| mem_rdata | input | 8*BUS_BYTES | Read data (the word contains the addressed byte) |
| exe_valid | output | 1 | Queue holds at least one byte |
| exe_byte | output | 8 | Oldest queued byte |
| exe_pop | input | 1 | Consume the oldest byte |

## Verification
An acknowledge sampled at a clock edge makes its bytes visible on `exe_valid`/`exe_byte` right after that edge. A pop or flush edge changes `exe_valid` by the next sample. A request rises one edge after the queue has room.

The bench changes inputs and reads outputs only at falling edges. So every check sees the state left by the preceding rising edge. Checks that wait on a fill allow a fixed margin of cycles well past the three-cycle fetch turnaround before they look at the result.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fetch_state_e;

    typedef struct packed {
        logic [1:0] n;    // bytes appended this cycle (0..2)
        logic [7:0] b0;   // lower-address byte
        logic [7:0] b1;   // upper-address byte, used when n == 2
    } push_t;

    function automatic logic [19:0] phys_addr(input logic [15:0] seg, input logic [15:0] off);
        return {seg, 4'h0} + {4'h0, off};
    endfunction

endpackage

// File: rtl/pfq_ring.sv
module pfq_ring
    import pfq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  push_t         push_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic [7:0]    head_o,
    output logic [CW-1:0] free_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    function automatic logic [IW-1:0] inc(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_pop  = pop_i && (cnt_q != '0);
    assign valid_o = (cnt_q != '0);
    assign head_o  = mem[rd_q];
    assign free_o  = CW'(DEPTH) - cnt_q;

    always_ff @(posedge clk) begin
        if (push_i.n != 2'd0) mem[wr_q] <= push_i.b0;
        if (push_i.n == 2'd2) mem[inc(wr_q)] <= push_i.b1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i.n == 2'd1)      wr_q <= inc(wr_q);
            else if (push_i.n == 2'd2) wr_q <= inc(inc(wr_q));
            if (do_pop) rd_q <= inc(rd_q);
            cnt_q <= cnt_q + CW'(push_i.n) - CW'(do_pop);
        end
    end

    // R2: occupancy bounded by the depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R2: the fetch side never appends more bytes than there are free slots
    p_push_fits_r2: assert property (@(posedge clk) disable iff (rst)
        (push_i.n != 2'd0) |-> (CW'(push_i.n) <= free_o));

    // R10: a pop on an empty queue leaves it empty when nothing arrives
    p_empty_pop_r10: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && pop_i && push_i.n == 2'd0) |=> !valid_o);

endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter int          BUS_BYTES = 2,
    parameter int          CW        = 3,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic [15:0]            new_seg,
    input  logic [15:0]            new_off,
    input  logic [CW-1:0]          free_i,
    output logic                   mem_req,
    output logic [19:0]            mem_addr,
    input  logic                   mem_ack,
    input  logic [BUS_BYTES*8-1:0] mem_rdata,
    output push_t                  push_o
);
    localparam int THR = BUS_BYTES;

    fetch_state_e state_q;
    logic [15:0]  seg_q, off_q;
    logic [19:0]  addr_q;
    logic         stale_q;
    logic         take;

    assign mem_req  = (state_q == FS_WAIT);
    assign mem_addr = addr_q;
    assign take     = mem_req && mem_ack && !stale_q && !flush;

    generate
        if (BUS_BYTES == 2) begin : g_wide
            always_comb begin
                push_o = '0;
                if (take) begin
                    if (addr_q[0]) begin
                        push_o.n  = 2'd1;
                        push_o.b0 = mem_rdata[15:8];
                    end else begin
                        push_o.n  = 2'd2;
                        push_o.b0 = mem_rdata[7:0];
                        push_o.b1 = mem_rdata[15:8];
                    end
                end
            end
        end else begin : g_narrow
            always_comb begin
                push_o = '0;
                if (take) begin
                    push_o.n  = 2'd1;
                    push_o.b0 = mem_rdata[7:0];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FS_IDLE;
            seg_q   <= RESET_SEG;
            off_q   <= RESET_OFF;
            addr_q  <= '0;
            stale_q <= 1'b0;
        end else if (flush) begin
            seg_q <= new_seg;
            off_q <= new_off;
            if (mem_req && !mem_ack) begin
                stale_q <= 1'b1;
            end else begin
                state_q <= FS_IDLE;
                stale_q <= 1'b0;
            end
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (free_i >= CW'(THR)) begin
                        state_q <= FS_WAIT;
                        addr_q  <= phys_addr(seg_q, off_q);
                    end
                end
                FS_WAIT: begin
                    if (mem_ack) begin
                        state_q <= FS_IDLE;
                        stale_q <= 1'b0;
                        off_q   <= off_q + 16'(push_o.n);
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // R12: an unanswered request keeps its address
    p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R3 / R4: a request only starts when the threshold of free slots was met
    p_issue_room_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(free_i) >= CW'(THR)));

endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int          DEPTH     = 6,
    parameter int          BUS_BYTES = 2,
    parameter logic [15:0] RESET_SEG = 16'hFFFF,
    parameter logic [15:0] RESET_OFF = 16'h0000
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush,
    input  logic [15:0]            flush_seg,
    input  logic [15:0]            flush_off,
    output logic                   mem_req,
    output logic [19:0]            mem_addr,
    input  logic                   mem_ack,
    input  logic [BUS_BYTES*8-1:0] mem_rdata,
    output logic                   exe_valid,
    output logic [7:0]             exe_byte,
    input  logic                   exe_pop
);
    localparam int CW = $clog2(DEPTH + 1);

    push_t         push;
    logic [CW-1:0] free;

    pfq_fetch #(
        .BUS_BYTES(BUS_BYTES),
        .CW       (CW),
        .RESET_SEG(RESET_SEG),
        .RESET_OFF(RESET_OFF)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .new_seg  (flush_seg),
        .new_off  (flush_off),
        .free_i   (free),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .push_o   (push)
    );

    pfq_ring #(
        .DEPTH(DEPTH),
        .CW   (CW)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .push_i (push),
        .pop_i  (exe_pop),
        .valid_o(exe_valid),
        .head_o (exe_byte),
        .free_o (free)
    );

    // R7: a flush leaves nothing visible to the execute side
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !exe_valid);

endmodule

// File: tb/prefetch_queue_test.sv
module pfq_mem_model #(
    parameter int BB = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  int              lat,
    input  logic            req,
    input  logic [19:0]     addr,
    output logic            ack,
    output logic [BB*8-1:0] rdata,
    output int              n_acks,
    output logic [19:0]     log_a [16]
);
    int wait_cnt;

    function automatic logic [7:0] mb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ack      <= 1'b0;
            wait_cnt <= 0;
            n_acks   <= 0;
            rdata    <= '0;
        end else begin
            ack <= 1'b0;
            if (req && !ack) begin
                if (wait_cnt >= lat) begin
                    ack      <= 1'b1;
                    wait_cnt <= 0;
                    if (BB == 2) rdata <= (BB*8)'({mb({addr[19:1], 1'b1}), mb({addr[19:1], 1'b0})});
                    else         rdata <= (BB*8)'(mb(addr));
                    log_a[n_acks % 16] <= addr;
                    n_acks <= n_acks + 1;
                end else begin
                    wait_cnt <= wait_cnt + 1;
                end
            end
        end
    end
endmodule

module prefetch_queue_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // wide instance
    logic        flush = 1'b0, pop = 1'b0;
    logic [15:0] fseg = '0, foff = '0;
    logic        req, ack, valid;
    logic [19:0] addr;
    logic [15:0] rdata;
    logic [7:0]  byte_o;
    int          lat = 0;
    int          n_acks;
    logic [19:0] log_a [16];

    // narrow instance
    logic        flush_n = 1'b0, pop_n = 1'b0;
    logic [15:0] fseg_n = '0, foff_n = '0;
    logic        req_n, ack_n, valid_n;
    logic [19:0] addr_n;
    logic [7:0]  rdata_n, byte_n;
    int          lat_n = 0;
    int          n_acks_n;
    logic [19:0] log_n [16];

    int total = 0, fails = 0;
    bit done = 1'b0;

    prefetch_queue #(.DEPTH(6), .BUS_BYTES(2)) uut (
        .clk(clk), .rst(rst), .flush(flush), .flush_seg(fseg), .flush_off(foff),
        .mem_req(req), .mem_addr(addr), .mem_ack(ack), .mem_rdata(rdata),
        .exe_valid(valid), .exe_byte(byte_o), .exe_pop(pop));

    prefetch_queue #(.DEPTH(4), .BUS_BYTES(1)) uut_n (
        .clk(clk), .rst(rst), .flush(flush_n), .flush_seg(fseg_n), .flush_off(foff_n),
        .mem_req(req_n), .mem_addr(addr_n), .mem_ack(ack_n), .mem_rdata(rdata_n),
        .exe_valid(valid_n), .exe_byte(byte_n), .exe_pop(pop_n));

    pfq_mem_model #(.BB(2)) m_w (.clk(clk), .rst(rst), .lat(lat), .req(req), .addr(addr),
        .ack(ack), .rdata(rdata), .n_acks(n_acks), .log_a(log_a));
    pfq_mem_model #(.BB(1)) m_n (.clk(clk), .rst(rst), .lat(lat_n), .req(req_n), .addr(addr_n),
        .ack(ack_n), .rdata(rdata_n), .n_acks(n_acks_n), .log_a(log_n));

    function automatic logic [7:0] eb(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]};
    endfunction

    function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
        logic [19:0] r;
        r = ({4'h0, s} << 4) + {4'h0, o};
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_flush(input bit nar, input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        if (nar) begin flush_n = 1'b1; fseg_n = s; foff_n = o; end
        else     begin flush   = 1'b1; fseg   = s; foff   = o; end
        @(negedge clk);
        flush = 1'b0; flush_n = 1'b0;
        if (nar) chk(!valid_n, "R7 narrow valid after flush", 32'(valid_n), 0);
        else     chk(!valid,   "R7 valid after flush",        32'(valid),   0);
    endtask

    // pops n bytes as they become valid and compares each with the model
    task automatic drain(input bit nar, input logic [15:0] s, input logic [15:0] o,
                         input int n, input string tag);
        int i = 0;
        int guard = 0;
        logic v;
        logic [7:0] b, e;
        while (i < n && guard < 400) begin
            @(negedge clk);
            guard++;
            v = nar ? valid_n : valid;
            b = nar ? byte_n : byte_o;
            if (v) begin
                e = eb(pa(s, o + 16'(i)));
                chk(b == e, tag, 32'(b), 32'(e));
                if (nar) pop_n = 1'b1; else pop = 1'b1;
                i++;
            end else begin
                pop = 1'b0; pop_n = 1'b0;
            end
        end
        @(negedge clk);
        pop = 1'b0; pop_n = 1'b0;
        chk(i == n, {tag, " byte count"}, 32'(i), 32'(n));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // {segment, offset, expected first physical address}
    localparam logic [51:0] VEC [5] = '{
        {16'h0000, 16'h0000, 20'h00000},
        {16'h1000, 16'h0010, 20'h10010},
        {16'hABCD, 16'h1235, 20'hACF05},
        {16'hFFFF, 16'h0011, 20'h00001},
        {16'h1234, 16'hFFFE, 20'h2233E}
    };

    initial begin
        int nb;
        logic [19:0] held;
        // reset state
        idle(3);
        chk(!valid && !req, "reset: wide outputs idle", {30'd0, valid, req}, 0);
        chk(!valid_n && !req_n, "reset: narrow outputs idle", {30'd0, valid_n, req_n}, 0);
        rst = 1'b0;
        idle(40);
        chk(log_a[0] == 20'hFFFF0, "R6 reset fetch address", 32'(log_a[0]), 32'h0FFFF0);
        chk(!req, "R2 full queue stops fetching", 32'(req), 0);

        // table walk: flush targets, address formation, fill limit, order
        for (int k = 0; k < 5; k++) begin
            logic [15:0] s, o, o2;
            logic [19:0] ex;
            s  = VEC[k][51:36];
            o  = VEC[k][35:20];
            ex = VEC[k][19:0];
            o2 = o + (o[0] ? 16'd1 : 16'd2);
            nb = n_acks;
            do_flush(1'b0, s, o);
            idle(40);
            chk(log_a[nb % 16] == ex, "R6/R7 first address after flush", 32'(log_a[nb % 16]), 32'(ex));
            chk(log_a[(nb + 1) % 16] == pa(s, o2), "R9/R11 second fetch address",
                32'(log_a[(nb + 1) % 16]), 32'(pa(s, o2)));
            chk(n_acks - nb == 3, "R2/R3 fetch count to fill", 32'(n_acks - nb), 3);
            chk(!req, "R3 no request with fewer than two free", 32'(req), 0);
            drain(1'b0, s, o, 14, "R1/R5/R11 byte order");
            idle(40);
        end

        // R8: flush while a request is outstanding
        lat = 6;
        do_flush(1'b0, 16'h2000, 16'h0100);
        @(negedge clk);
        chk(req == 1'b1, "R8 request outstanding", 32'(req), 1);
        chk(addr == 20'h20100, "R6 outstanding address", 32'(addr), 32'h20100);
        held = addr;
        @(negedge clk);
        chk(req && addr == held, "R12 request held stable", 32'(addr), 32'(held));
        do_flush(1'b0, 16'h3000, 16'h0007);
        drain(1'b0, 16'h3000, 16'h0007, 8, "R8 stale data dropped");
        idle(60);

        // R10: pops on an empty queue
        lat = 10;
        do_flush(1'b0, 16'h0500, 16'h0003);
        pop = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(!valid, "R10 empty while popping", 32'(valid), 0);
        end
        pop = 1'b0;
        drain(1'b0, 16'h0500, 16'h0003, 6, "R10 no byte swallowed");
        lat = 0;
        idle(60);

        // narrow variant
        nb = n_acks_n;
        do_flush(1'b1, 16'h0100, 16'h0020);
        idle(40);
        chk(n_acks_n - nb == 4, "R2 narrow fills four bytes", 32'(n_acks_n - nb), 4);
        chk(!req_n, "R4 narrow full no request", 32'(req_n), 0);
        chk(byte_n == eb(20'h01020), "R1 narrow head byte", 32'(byte_n), 32'(eb(20'h01020)));
        pop_n = 1'b1;
        @(negedge clk);
        pop_n = 1'b0;
        @(negedge clk);
        chk(req_n == 1'b1, "R4 narrow request after one pop", 32'(req_n), 1);
        drain(1'b1, 16'h0100, 16'h0021, 9, "R1/R5 narrow order");

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule